// File: doc/BRIEF.md
# Circular Ring Burst Writer

This block sits between a word-oriented packet receiver and a memory write port. Incoming 32-bit words arrive on a valid/ready stream and are held in a 32-entry internal FIFO. A controller drains the FIFO into memory as write bursts of 1, 4 or 8 beats. The destination is a ring defined by a word-aligned base address and a size in words, and that size must be a whole number of 47-word packets.

When the word at the last ring location is accepted by memory, the block pulses an interrupt and the next write goes back to the base address. Bursts never run past the end of the ring. When fewer words remain before the wrap point than the burst length, the controller issues single-beat writes up to that point.

The controller has three states. In IDLE the ring offset is held at zero. The transition `start` (IDLE→WAIT) is taken when the block is enabled and the configuration is valid. In WAIT, the transition `launch` (WAIT→BURST) is taken once the FIFO holds enough words for the chosen burst length, and the transition `stop` (WAIT→IDLE) is taken when the block is disabled or the configuration is invalid. In BURST the beats are issued; after the final beat, the transition `next` (BURST→WAIT) is taken if the block is still running, and `halt` (BURST→IDLE) otherwise.

Top module: `ring_burst_writer`

## Requirements
- R1: The FIFO holds up to 32 words. `in_ready` is low exactly when it is full. Words reach memory in arrival order, with none dropped and none duplicated.
- R2: `cfg_burst_sel` picks the burst length: 0 gives 1 beat, 1 gives 4 beats, and 2 or 3 gives 8 beats. `wr_last` is high only on the final beat of each burst.
- R3: A burst starts only when the FIFO holds at least as many words as the burst will carry. Words that cannot fill such a burst stay queued.
- R4: The write address is the base address (low two bits forced to zero) plus 4 times the ring offset. It advances by 4 bytes per accepted beat, so its two low bits are always zero.
- R5: No burst crosses the end of the ring. If fewer words remain before the wrap point than the burst length, single-beat writes are issued up to the wrap point.
- R6: `buf_full_irq` is a one-cycle pulse in the cycle memory accepts the word at the last ring location. The next write after it goes to the base address.
- R7: `cfg_err` is set one cycle after the ring size is zero or not a multiple of 47. While it is set, no burst is started.
- R8: Clearing `en` lets a burst in progress complete. After that no new burst starts, and the next burst after re-enabling goes to the base address.
- R9: After reset, `wr_valid` and `buf_full_irq` are low and `in_ready` is high.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_last` hold steady and `wr_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| cfg_base | input | 32 | Ring base byte address |
| cfg_size_words | input | 16 | Ring size in words |
| cfg_burst_sel | input | 2 | Burst length select |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | FIFO can accept a word |
| wr_valid | output | 1 | Memory write beat valid |
| wr_addr | output | 32 | Beat byte address |
| wr_data | output | 32 | Beat data |
| wr_last | output | 1 | Final beat of burst |
| wr_ready | input | 1 | Memory accepts beat |
| buf_full_irq | output | 1 | Ring-full pulse |
| cfg_err | output | 1 | Invalid ring size flag |

## Verification
The assertions assume that base address, size and burst select are stable whenever `en` is high, and that a burst once presented is eventually accepted by memory. The bench therefore changes configuration only while `en` is low and the controller is idle. It also always releases `wr_ready` after a stall. Stalls take two forms: a toggling ready, and a long hold that fills the FIFO to test backpressure.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } rbw_state_e;

    // Burst select decode: 0 -> 1 beat, 1 -> 4 beats, 2/3 -> 8 beats
    function automatic logic [3:0] sel_to_beats(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 4'd1;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/rbw_fifo.sv
module rbw_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= push_data;
    end

    assign head  = mem[rd_ptr_q];
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/rbw_cfg_check.sv
module rbw_cfg_check #(
    parameter int SIZE_W    = 16,
    parameter int PKT_WORDS = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] size_words,
    output logic              err
);
    logic bad;
    assign bad = (size_words == '0) || ((size_words % SIZE_W'(PKT_WORDS)) != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= bad;
    end
endmodule

// File: rtl/rbw_ring_ptr.sv
module rbw_ring_ptr #(
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    input  logic [SIZE_W-1:0] size_words,
    output logic [SIZE_W-1:0] offset,
    output logic [SIZE_W-1:0] remaining,
    output logic              at_end
);
    logic [SIZE_W-1:0] off_q;

    assign at_end    = (off_q == size_words - 1'b1);
    assign remaining = size_words - off_q;
    assign offset    = off_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) off_q <= '0;
        else if (adv)        off_q <= at_end ? '0 : off_q + 1'b1;
    end
endmodule

// File: rtl/ring_burst_writer.sv
module ring_burst_writer #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 16,
    parameter int FIFO_DEPTH = 32,
    parameter int PKT_WORDS  = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size_words,
    input  logic [1:0]        cfg_burst_sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    input  logic              wr_ready,
    output logic              buf_full_irq,
    output logic              cfg_err
);
    import rbw_pkg::*;

    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    rbw_state_e        state_q, state_d;
    logic [3:0]        beats_q, beat_idx_q;
    logic [3:0]        sel_beats, len_next;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, pop, run, beat_done, final_beat;
    logic [SIZE_W-1:0] offset, remaining;
    logic              at_end;

    assign run       = en && !cfg_err;
    assign sel_beats = sel_to_beats(cfg_burst_sel);
    assign len_next  = (remaining >= SIZE_W'(sel_beats)) ? sel_beats : 4'd1;

    rbw_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(in_valid && !fifo_full), .push_data(in_data),
        .pop(pop), .head(wr_data), .count(fifo_cnt), .full(fifo_full)
    );

    rbw_cfg_check #(.SIZE_W(SIZE_W), .PKT_WORDS(PKT_WORDS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .size_words(cfg_size_words), .err(cfg_err)
    );

    rbw_ring_ptr #(.SIZE_W(SIZE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_IDLE), .adv(pop),
        .size_words(cfg_size_words),
        .offset(offset), .remaining(remaining), .at_end(at_end)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!run)                              state_d = ST_IDLE;
                else if (fifo_cnt >= CNT_W'(len_next)) state_d = ST_BURST;
            end
            ST_BURST: if (beat_done && final_beat) state_d = run ? ST_WAIT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and burst counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            beats_q    <= 4'd1;
            beat_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && state_d == ST_BURST) begin
                beats_q    <= len_next;
                beat_idx_q <= '0;
            end else if (beat_done) begin
                beat_idx_q <= beat_idx_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        wr_valid     = (state_q == ST_BURST);
        beat_done    = wr_valid && wr_ready;
        final_beat   = (beat_idx_q == beats_q - 4'd1);
        wr_last      = wr_valid && final_beat;
        pop          = beat_done;
        buf_full_irq = beat_done && at_end;
        in_ready     = !fifo_full;
        wr_addr      = {cfg_base[ADDR_W-1:2] + (ADDR_W-2)'(offset), 2'b00};
    end
endmodule

// File: rtl/rbw_checker.sv
module rbw_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int DEPTH  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_last,
    input logic              buf_full_irq,
    input logic              cfg_err,
    input logic [CNT_W-1:0]  fifo_cnt
);
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    p_ready_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> fifo_cnt == CNT_W'(DEPTH));

    p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last |-> wr_valid);

    p_burst_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> fifo_cnt != '0);

    p_addr_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_addr[1:0] == 2'b00);

    p_irq_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full_irq |-> wr_valid && wr_ready);

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full_irq |=> !buf_full_irq);

    p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err && !wr_valid |=> !wr_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last));
endmodule

bind ring_burst_writer rbw_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
    .buf_full_irq(buf_full_irq), .cfg_err(cfg_err), .fifo_cnt(fifo_cnt)
);

// File: tb/ring_burst_writer_tb.sv
module ring_burst_writer_tb;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int NV = 4;
    localparam int V_SEL  [NV] = '{1, 2, 0, 2};
    localparam int V_SIZE [NV] = '{47, 94, 47, 47};
    localparam int V_N    [NV] = '{47, 102, 50, 47};
    localparam int V_MODE [NV] = '{0, 0, 1, 2};   // 0 ready, 1 toggle, 2 long stall

    logic clk = 0, rst_n = 0, en = 0, in_valid = 0, wr_ready = 1;
    logic [31:0] cfg_base = BASE, in_data = 0;
    logic [15:0] cfg_size_words = 16'd47;
    logic [1:0]  cfg_burst_sel = 0;
    logic in_ready, wr_valid, wr_last, buf_full_irq, cfg_err;
    logic [31:0] wr_addr, wr_data;

    int checks = 0, fails = 0, cap_n = 0, nexp = 0;
    bit done = 0;
    logic [31:0] cap_addr [256], cap_data [256], exp_addr [256];
    bit cap_last [256], cap_irq [256], exp_last [256], exp_irq [256];

    always #10 clk = ~clk;

    ring_burst_writer u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_base(cfg_base),
        .cfg_size_words(cfg_size_words), .cfg_burst_sel(cfg_burst_sel),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
        .wr_ready(wr_ready), .buf_full_irq(buf_full_irq), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        if (wr_valid && wr_ready && cap_n < 256) begin
            cap_addr[cap_n] = wr_addr;
            cap_data[cap_n] = wr_data;
            cap_last[cap_n] = wr_last;
            cap_irq[cap_n]  = buf_full_irq;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_words(input int n, input logic [31:0] seed);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            in_valid = 1;
            in_data  = seed + k;
            if (in_ready) k++;
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic drive_ready(input int mode);
        if (mode == 1) begin
            for (int c = 0; c < 3000 && cap_n < nexp; c++) begin
                @(posedge clk); #1 wr_ready = ~wr_ready;
            end
            wr_ready = 1;
        end else if (mode == 2) begin
            @(posedge clk); #1 wr_ready = 0;
            repeat (50) @(negedge clk);
            chk(in_ready == 0, "R1 full fifo deasserts ready", in_ready, 0);
            chk(wr_valid == 1 && cap_n == 0, "R10 stalled beat held", wr_valid, 1);
            @(posedge clk); #1 wr_ready = 1;
        end else begin
            wr_ready = 1;
        end
    endtask

    // Expected write stream from R2/R4/R5/R6
    task automatic build_exp(input int sel, input int size, input int n);
        int blen, off;
        blen = (sel == 0) ? 1 : ((sel == 1) ? 4 : 8);
        off = 0;
        nexp = 0;
        while (1) begin
            int len;
            len = (size - off >= blen) ? blen : 1;
            if (nexp + len > n) break;
            for (int b = 0; b < len; b++) begin
                exp_addr[nexp] = BASE + 32'(4 * off);
                exp_last[nexp] = (b == len - 1);
                exp_irq[nexp]  = (off == size - 1);
                off = (off == size - 1) ? 0 : off + 1;
                nexp++;
            end
        end
    endtask

    task automatic wait_caps(input int target);
        for (int c = 0; c < 3000 && cap_n < target; c++) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state (R9)
        chk(wr_valid == 0, "R9 wr_valid after reset", wr_valid, 0);
        chk(buf_full_irq == 0, "R9 irq after reset", buf_full_irq, 0);
        chk(in_ready == 1, "R9 in_ready after reset", in_ready, 1);

        // Invalid size blocks writes (R7)
        cfg_size_words = 16'd50; cfg_burst_sel = 2'd1;
        repeat (2) @(negedge clk);
        chk(cfg_err == 1, "R7 size 50 flagged", cfg_err, 1);
        cfg_size_words = 16'd0;
        repeat (2) @(negedge clk);
        chk(cfg_err == 1, "R7 size 0 flagged", cfg_err, 1);
        en = 1;
        push_words(4, 32'hE000);
        repeat (20) @(negedge clk);
        chk(cap_n == 0, "R7 no write while err", cap_n, 0);
        cfg_size_words = 16'd47;
        wait_caps(4);
        chk(cfg_err == 0, "R7 err clears", cfg_err, 0);
        chk(cap_n == 4, "R7 queued words drain", cap_n, 4);
        chk(cap_addr[0] == BASE && cap_data[3] == 32'hE003 && cap_last[3], "R7 drained burst", cap_addr[0], BASE);
        en = 0;
        repeat (5) @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            cfg_burst_sel  = 2'(V_SEL[i]);
            cfg_size_words = 16'(V_SIZE[i]);
            build_exp(V_SEL[i], V_SIZE[i], V_N[i]);
            cap_n = 0;
            @(negedge clk);
            en = 1;
            fork
                push_words(V_N[i], 32'(i) << 16);
                drive_ready(V_MODE[i]);
            join
            wait_caps(nexp);
            chk(cap_n == nexp, "R3 R5 write count", cap_n, nexp);
            for (int j = 0; j < nexp; j++) begin
                chk(cap_addr[j] == exp_addr[j], "R4 R5 address", cap_addr[j], exp_addr[j]);
                chk(cap_data[j] == ((32'(i) << 16) + 32'(j)), "R1 order", cap_data[j], (32'(i) << 16) + 32'(j));
                chk(cap_last[j] == exp_last[j], "R2 last flag", 32'(cap_last[j]), 32'(exp_last[j]));
                chk(cap_irq[j] == exp_irq[j], "R6 irq on final ring word", 32'(cap_irq[j]), 32'(exp_irq[j]));
            end
            en = 0;
            repeat (5) @(negedge clk);
        end

        // Disable during a burst (R8)
        cfg_burst_sel = 2'd2; cfg_size_words = 16'd47;
        cap_n = 0;
        wr_ready = 0;
        en = 1;
        push_words(8, 32'hA000);
        repeat (5) @(negedge clk);
        chk(wr_valid == 1, "R8 burst begun", wr_valid, 1);
        en = 0;
        repeat (5) @(negedge clk);
        chk(wr_valid == 1, "R8 burst kept after disable", wr_valid, 1);
        @(posedge clk); #1 wr_ready = 1;
        repeat (20) @(negedge clk);
        chk(cap_n == 8 && cap_last[7], "R8 burst completes", cap_n, 8);
        push_words(8, 32'hB000);
        repeat (20) @(negedge clk);
        chk(cap_n == 8, "R8 no burst while disabled", cap_n, 8);
        en = 1;
        wait_caps(16);
        chk(cap_n == 16, "R8 resume count", cap_n, 16);
        chk(cap_addr[8] == BASE, "R8 resume at base", cap_addr[8], BASE);
        chk(cap_data[8] == 32'hB000, "R1 order after resume", cap_data[8], 32'hB000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule